// File: doc/BRIEF.md
# Cluster private peripheral region decoder

This block is the register-bus front end of the private peripheral window that every core of a small cluster (one to four CPUs) sees at the same base address. A request carries an address inside the 8 KiB region, a write flag, write data and the index of the CPU that issued it. The block holds the snoop-control register bank itself. Every other access it steers to one of the downstream peripherals: a per-CPU interrupt CPU interface, the shared interrupt distributor, or a per-CPU timer or watchdog. For each such access it raises a one-cycle select strobe and passes a local offset, the write flag and the write data along. The peripherals answer combinationally on their read-data lanes in the same cycle.

Two windows are "self" aliases: the interface window at 0x100 and the timer/watchdog window at 0x600 both resolve to the CPU named on `req_cpu`. The configuration register is not stored. Its value is built from the CPU-count parameter. The block also wires each CPU's timer and watchdog interrupt lines onto fixed bits of that CPU's 32-bit private interrupt vector.

The request side uses valid/ready and the response side uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or the waiting response is being taken in the same cycle. A response appears in the cycle after acceptance. It stays, unchanged, until `rsp_ready` is high. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `cluster_priv_region`

## Requirements
- R1: The control register at offset 0x000 resets to 0. A write stores only bit 0 of the data. A read returns the stored bit in bit 0, with bits 31:1 zero and no error.
- R2: Reading offset 0x004 returns ((2^N − 1) << 4) | (N − 1), where N is the parameter NCPU. For N = 3 this is 0x72.
- R3: Offsets 0x008 and 0x00C read zero without error. Writes to 0x004, 0x008 and 0x00C complete without error and change no readable state.
- R4: Any other offset below 0x100 (including unaligned ones) returns zero data with `rsp_err` set. A write there changes nothing.
- R5: Offsets 0x100–0x1FF select the interrupt CPU interface of the requesting CPU. Offsets 0x200 + i·0x100 … +0xFF select the interface of CPU i. In both cases the local offset is address bits 7:0.
- R6: Windows at 0x600 + k·0x100 (k = 0…4) hold a timer at in-window offsets 0x00–0x1F and a watchdog at 0x20–0x3F, with local offset = address bits 4:0. Window k = 0 selects the requesting CPU and window k ≥ 1 selects CPU k − 1. In-window offsets 0x40–0xFF are unmapped.
- R7: Offsets 0x1000–0x1FFF select the distributor, with local offset = address bits 11:0.
- R8: An access is unmapped if it names a CPU index ≥ N (directly, or through an alias with `req_cpu` ≥ N), or if it lands in 0xB00–0xFFF. Such an access raises no strobe and returns zero data with `rsp_err` set.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. `rsp_valid` rises in the cycle after acceptance, and `rsp_rdata`/`rsp_err` hold stable while `rsp_valid` is high and `rsp_ready` is low. Reset clears `rsp_valid`.
- R10: For each CPU i, bit i·32+29 of `ppi_out` follows `tmr_irq[i]`, bit i·32+30 follows `wdg_irq[i]`, and all other bits are zero.
- R11: An accepted mapped peripheral access raises exactly one of `cpuif_sel[i]`, `tmr_sel[i]`, `wdg_sel[i]` or `dist_sel`, and only in its acceptance cycle. In that cycle `tgt_addr`, `tgt_we` and `tgt_wdata` carry the local offset, the write flag and the write data. A write response returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 13 | Byte offset inside the region |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the requesting CPU |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Bad offset or unmapped access |
| tgt_addr | output | 12 | Local offset toward the selected peripheral |
| tgt_we | output | 1 | Write flag toward the peripheral |
| tgt_wdata | output | 32 | Write data toward the peripheral |
| cpuif_sel | output | NCPU | Strobe per interrupt CPU interface |
| dist_sel | output | 1 | Distributor strobe |
| tmr_sel | output | NCPU | Strobe per timer |
| wdg_sel | output | NCPU | Strobe per watchdog |
| cpuif_rdata | input | 32·NCPU | Interface read lanes, lane i for CPU i |
| dist_rdata | input | 32 | Distributor read data |
| tmr_rdata | input | 32·NCPU | Timer read lanes |
| wdg_rdata | input | 32·NCPU | Watchdog read lanes |
| tmr_irq | input | NCPU | Timer interrupt per CPU |
| wdg_irq | input | NCPU | Watchdog interrupt per CPU |
| ppi_out | output | 32·NCPU | Private interrupt vector per CPU |

## Verification
The only stored state is the control bit and the response register. A corrupted control bit shows up on the next read of offset 0x000, one cycle after that read is accepted. A corrupted response register shows up either as a lost or duplicated `rsp_valid`, or as data or an error flag that changes during a stall. The bench compares this register against its model on every clock, so such a fault is caught within the cycle. A wrong window decode is combinational: it shows a misplaced strobe or local offset in the acceptance cycle itself. It then shows the wrong peripheral's lane pattern in the response one cycle later.

// File: rtl/cluster_priv_pkg.sv
package cluster_priv_pkg;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 32;
  localparam int LOC_W    = 12;
  localparam int PPI_W    = 32;
  localparam int TMR_PPI  = 29;
  localparam int WDG_PPI  = 30;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SCU,
    TGT_CPUIF,
    TGT_DIST,
    TGT_TMR,
    TGT_WDG
  } tgt_e;
endpackage

// File: rtl/priv_addr_decode.sv
module priv_addr_decode
  import cluster_priv_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cpu_id,
  output tgt_e              tgt,
  output logic [1:0]        idx,
  output logic [LOC_W-1:0]  loc
);
  localparam logic [2:0] NCPU_L = 3'(NCPU);
  localparam logic [3:0] PG_SCU   = 4'd0;
  localparam logic [3:0] PG_SELF  = 4'd1;
  localparam logic [3:0] PG_IFLST = 4'd5;
  localparam logic [3:0] PG_TSELF = 4'd6;
  localparam logic [3:0] PG_TLAST = 4'd10;

  logic [3:0] page;
  tgt_e       raw_tgt;

  assign page = addr[11:8];

  always_comb begin
    raw_tgt = TGT_NONE;
    idx     = 2'd0;
    loc     = '0;
    if (addr[12]) begin
      raw_tgt = TGT_DIST;
      loc     = addr[11:0];
    end else if (page == PG_SCU) begin
      raw_tgt = TGT_SCU;
      loc     = {4'd0, addr[7:0]};
    end else if (page <= PG_IFLST) begin
      raw_tgt = TGT_CPUIF;
      idx     = (page == PG_SELF) ? cpu_id : 2'(page - 4'd2);
      loc     = {4'd0, addr[7:0]};
    end else if (page <= PG_TLAST) begin
      idx = (page == PG_TSELF) ? cpu_id : 2'(page - 4'd7);
      loc = {7'd0, addr[4:0]};
      if (addr[7:6] == 2'b00) begin
        raw_tgt = addr[5] ? TGT_WDG : TGT_TMR;
      end
    end
  end

  always_comb begin
    tgt = raw_tgt;
    if ((raw_tgt == TGT_CPUIF || raw_tgt == TGT_TMR || raw_tgt == TGT_WDG) &&
        !({1'b0, idx} < NCPU_L)) begin
      tgt = TGT_NONE;
    end
  end
endmodule

// File: rtl/priv_scu_regs.sv
module priv_scu_regs
  import cluster_priv_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              bad
);
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_INV  = 8'h0C;
  localparam logic [DATA_W-1:0] CFG_VAL =
    DATA_W'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

  logic ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
    end else if (wr_en && off == OFF_CTRL) begin
      ctrl_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    bad   = 1'b0;
    unique case (off)
      OFF_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
      OFF_CFG:  rdata = CFG_VAL;
      OFF_STAT: rdata = '0;
      OFF_INV:  rdata = '0;
      default:  bad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/priv_irq_route.sv
module priv_irq_route
  import cluster_priv_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [NCPU-1:0]       tmr_irq,
  input  logic [NCPU-1:0]       wdg_irq,
  output logic [NCPU*PPI_W-1:0] ppi_out
);
  for (genvar gi = 0; gi < NCPU; gi++) begin : g_cpu
    always_comb begin
      ppi_out[gi*PPI_W +: PPI_W]          = '0;
      ppi_out[gi*PPI_W + TMR_PPI]         = tmr_irq[gi];
      ppi_out[gi*PPI_W + WDG_PPI]         = wdg_irq[gi];
    end
  end
endmodule

// File: rtl/cluster_priv_region.sv
module cluster_priv_region
  import cluster_priv_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0]             req_cpu,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_err,
  output logic [LOC_W-1:0]       tgt_addr,
  output logic                   tgt_we,
  output logic [DATA_W-1:0]      tgt_wdata,
  output logic [NCPU-1:0]        cpuif_sel,
  output logic                   dist_sel,
  output logic [NCPU-1:0]        tmr_sel,
  output logic [NCPU-1:0]        wdg_sel,
  input  logic [NCPU*DATA_W-1:0] cpuif_rdata,
  input  logic [DATA_W-1:0]      dist_rdata,
  input  logic [NCPU*DATA_W-1:0] tmr_rdata,
  input  logic [NCPU*DATA_W-1:0] wdg_rdata,
  input  logic [NCPU-1:0]        tmr_irq,
  input  logic [NCPU-1:0]        wdg_irq,
  output logic [NCPU*PPI_W-1:0]  ppi_out
);
  tgt_e              tgt;
  logic [1:0]        idx;
  logic [LOC_W-1:0]  loc;
  logic              fire;
  logic [DATA_W-1:0] scu_rdata;
  logic              scu_bad;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_err;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  priv_addr_decode #(.NCPU(NCPU)) u_dec (
    .addr   (req_addr),
    .cpu_id (req_cpu),
    .tgt    (tgt),
    .idx    (idx),
    .loc    (loc)
  );

  priv_scu_regs #(.NCPU(NCPU)) u_scu (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (fire && req_we && tgt == TGT_SCU),
    .off   (loc[7:0]),
    .wdata (req_wdata),
    .rdata (scu_rdata),
    .bad   (scu_bad)
  );

  priv_irq_route #(.NCPU(NCPU)) u_irq (
    .tmr_irq (tmr_irq),
    .wdg_irq (wdg_irq),
    .ppi_out (ppi_out)
  );

  assign tgt_addr  = loc;
  assign tgt_we    = req_we;
  assign tgt_wdata = req_wdata;
  assign dist_sel  = fire && tgt == TGT_DIST;

  for (genvar gi = 0; gi < NCPU; gi++) begin : g_sel
    assign cpuif_sel[gi] = fire && tgt == TGT_CPUIF && idx == 2'(gi);
    assign tmr_sel[gi]   = fire && tgt == TGT_TMR   && idx == 2'(gi);
    assign wdg_sel[gi]   = fire && tgt == TGT_WDG   && idx == 2'(gi);
  end

  always_comb begin
    rd_mux = '0;
    rd_err = 1'b0;
    unique case (tgt)
      TGT_SCU: begin
        rd_mux = scu_rdata;
        rd_err = scu_bad;
      end
      TGT_DIST: rd_mux = dist_rdata;
      TGT_CPUIF: begin
        for (int i = 0; i < NCPU; i++) begin
          if (idx == 2'(i)) rd_mux = cpuif_rdata[i*DATA_W +: DATA_W];
        end
      end
      TGT_TMR: begin
        for (int i = 0; i < NCPU; i++) begin
          if (idx == 2'(i)) rd_mux = tmr_rdata[i*DATA_W +: DATA_W];
        end
      end
      TGT_WDG: begin
        for (int i = 0; i < NCPU; i++) begin
          if (idx == 2'(i)) rd_mux = wdg_rdata[i*DATA_W +: DATA_W];
        end
      end
      default: rd_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (req_we || rd_err) ? '0 : rd_mux;
      rsp_err   <= rd_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cluster_priv_region_chk.sv
module cluster_priv_region_chk
  import cluster_priv_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  req_we,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [DATA_W-1:0]     rsp_rdata,
  input logic                  rsp_err,
  input logic [NCPU-1:0]       cpuif_sel,
  input logic                  dist_sel,
  input logic [NCPU-1:0]       tmr_sel,
  input logic [NCPU-1:0]       wdg_sel,
  input logic [NCPU-1:0]       tmr_irq,
  input logic [NCPU-1:0]       wdg_irq,
  input logic [NCPU*PPI_W-1:0] ppi_out
);
  localparam logic [DATA_W-1:0] CFG_EXP =
    DATA_W'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

  logic                  acc;
  logic [3*NCPU:0]       sels;

  assign acc  = req_valid && req_ready;
  assign sels = {cpuif_sel, tmr_sel, wdg_sel, dist_sel};

  p_ctrl_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_we && req_addr == 13'h000 |=> rsp_rdata[31:1] == '0 && !rsp_err);

  p_cfg_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_we && req_addr == 13'h004 |=> rsp_rdata == CFG_EXP && !rsp_err);

  p_bad_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr < 13'h100 && req_addr[1:0] != 2'b00 |=> rsp_err && rsp_rdata == '0);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr >= 13'h100 && sels == '0 |=> rsp_err && rsp_rdata == '0);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  p_idle_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> sels == '0);

  for (genvar gi = 0; gi < NCPU; gi++) begin : g_irq
    p_ppi_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ppi_out[gi*PPI_W + TMR_PPI] == tmr_irq[gi] &&
      ppi_out[gi*PPI_W + WDG_PPI] == wdg_irq[gi] &&
      $countones(ppi_out[gi*PPI_W +: PPI_W]) == 32'(tmr_irq[gi]) + 32'(wdg_irq[gi]));
  end
endmodule

bind cluster_priv_region cluster_priv_region_chk #(.NCPU(NCPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .cpuif_sel (cpuif_sel),
  .dist_sel  (dist_sel),
  .tmr_sel   (tmr_sel),
  .wdg_sel   (wdg_sel),
  .tmr_irq   (tmr_irq),
  .wdg_irq   (wdg_irq),
  .ppi_out   (ppi_out)
);

// File: tb/tb_cluster_priv_region.sv
module tb_cluster_priv_region;
  localparam int N = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [12:0]   req_addr = '0;
  logic          req_we = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_cpu = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic [11:0]   tgt_addr;
  logic          tgt_we;
  logic [31:0]   tgt_wdata;
  logic [N-1:0]  cpuif_sel, tmr_sel, wdg_sel;
  logic          dist_sel;
  logic [N*32-1:0] cpuif_rdata, tmr_rdata, wdg_rdata;
  logic [31:0]   dist_rdata;
  logic [N-1:0]  tmr_irq = '0, wdg_irq = '0;
  logic [N*32-1:0] ppi_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit ctrl_m = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cluster_priv_region #(.NCPU(N)) dut (.*);

  // responders: lane pattern identifies peripheral, CPU and local offset
  always_comb begin
    for (int i = 0; i < N; i++) begin
      cpuif_rdata[i*32 +: 32] = 32'h1100_0000 | (32'(i) << 16) | {20'd0, tgt_addr};
      tmr_rdata[i*32 +: 32]   = 32'h3300_0000 | (32'(i) << 16) | {20'd0, tgt_addr};
      wdg_rdata[i*32 +: 32]   = 32'h4400_0000 | (32'(i) << 16) | {20'd0, tgt_addr};
    end
    dist_rdata = 32'h2200_0000 | {20'd0, tgt_addr};
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // kind: 0 none, 1 scu, 2 cpuif, 3 dist, 4 timer, 5 watchdog
  task automatic model(input int a, input int cpu, output int kind, output int idx, output int loc);
    int k, off;
    kind = 0; idx = 0; loc = 0;
    if (a >= 'h1000) begin kind = 3; loc = a - 'h1000; end
    else if (a < 'h100) begin kind = 1; loc = a; end
    else if (a < 'h200) begin kind = 2; idx = cpu; loc = a - 'h100; end
    else if (a < 'h600) begin kind = 2; idx = (a - 'h200) / 256; loc = a % 256; end
    else if (a < 'hB00) begin
      k = (a - 'h600) / 256; off = a % 256;
      idx = (k == 0) ? cpu : k - 1;
      if (off < 32) begin kind = 4; loc = off; end
      else if (off < 64) begin kind = 5; loc = off - 32; end
    end
    if ((kind == 2 || kind == 4 || kind == 5) && idx >= N) kind = 0;
  endtask

  task automatic step(input bit v, input int a, input bit we, input logic [31:0] wd,
                      input int cpu, input bit rr, input string rq, output bit acc);
    int kind, idx, loc;
    bit exp_rdy;
    logic [N-1:0] e_if, e_tm, e_wd;
    logic [31:0] ed;
    bit ee;
    @(negedge clk);
    cyc++;
    req_valid = v; req_addr = 13'(a); req_we = we; req_wdata = wd; req_cpu = 2'(cpu);
    rsp_ready = rr;
    tmr_irq = N'(cyc); wdg_irq = N'(cyc >> 2);
    #1;
    exp_rdy = (exp_q.size() == 0) || rr;
    chk(req_ready == exp_rdy, "R9 ready", 64'(req_ready), 64'(exp_rdy));
    chk(rsp_valid == (exp_q.size() != 0), "R9 rsp_valid", 64'(rsp_valid), 64'(exp_q.size() != 0));
    if (exp_q.size() != 0) begin
      chk({rsp_err, rsp_rdata} == exp_q[0], {tag_q[0], " response"},
          64'({rsp_err, rsp_rdata}), 64'(exp_q[0]));
      if (rr) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
    end
    for (int i = 0; i < N; i++) begin
      logic [31:0] ev;
      ev = '0; ev[29] = tmr_irq[i]; ev[30] = wdg_irq[i];
      chk(ppi_out[i*32 +: 32] == ev, "R10 ppi", 64'(ppi_out[i*32 +: 32]), 64'(ev));
    end
    model(a, cpu, kind, idx, loc);
    acc = v && exp_rdy;
    e_if = '0; e_tm = '0; e_wd = '0;
    if (acc && kind == 2) e_if[idx] = 1'b1;
    if (acc && kind == 4) e_tm[idx] = 1'b1;
    if (acc && kind == 5) e_wd[idx] = 1'b1;
    chk({cpuif_sel, tmr_sel, wdg_sel, dist_sel} == {e_if, e_tm, e_wd, acc && kind == 3},
        {rq, " R11 strobes"}, 64'({cpuif_sel, tmr_sel, wdg_sel, dist_sel}),
        64'({e_if, e_tm, e_wd, acc && kind == 3}));
    if (acc && kind >= 2) begin
      chk({tgt_addr, tgt_we, tgt_wdata} == {12'(loc), we, wd}, {rq, " R11 target fields"},
          64'({tgt_addr, tgt_we, tgt_wdata}), 64'({12'(loc), we, wd}));
    end
    if (acc) begin
      ed = '0; ee = 0;
      case (kind)
        0: ee = 1;
        1: begin
          if (loc == 0) ed = {31'd0, ctrl_m};
          else if (loc == 4) ed = ((32'd1 << N) - 1) << 4 | 32'(N - 1);
          else if (loc == 8 || loc == 'hC) ed = '0;
          else ee = 1;
          if (we && loc == 0) ctrl_m = wd[0];
        end
        2: ed = 32'h1100_0000 | (32'(idx) << 16) | 32'(loc);
        3: ed = 32'h2200_0000 | 32'(loc);
        4: ed = 32'h3300_0000 | (32'(idx) << 16) | 32'(loc);
        default: ed = 32'h4400_0000 | (32'(idx) << 16) | 32'(loc);
      endcase
      if (we || ee) ed = '0;
      exp_q.push_back({ee, ed});
      tag_q.push_back(rq);
    end
  endtask

  task automatic xfer(input int a, input bit we, input logic [31:0] wd, input int cpu, input string rq);
    bit ok = 0;
    while (!ok) step(1, a, we, wd, cpu, 1, rq, ok);
  endtask

  task automatic idle(input int n);
    bit ok;
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 1, "idle", ok);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(2);                                   // R9 reset: no response pending

    xfer('h000, 0, '0, 0, "R1 reset value");
    xfer('h000, 1, 32'hFFFF_FFFF, 1, "R1 write all ones");
    xfer('h000, 0, '0, 2, "R1 read bit0");
    xfer('h000, 1, 32'h0000_0002, 0, "R1 write bit1 only");
    xfer('h000, 0, '0, 0, "R1 bit0 cleared");
    xfer('h000, 1, 32'h0000_0001, 0, "R1 set");

    xfer('h004, 0, '0, 0, "R2 config");
    xfer('h004, 1, '0, 0, "R3 write config");
    xfer('h004, 0, '0, 1, "R3 config unchanged");
    xfer('h008, 0, '0, 0, "R3 status");
    xfer('h00C, 0, '0, 0, "R3 invalidate read");
    xfer('h00C, 1, 32'hFFFF_FFFE, 0, "R3 invalidate write");
    xfer('h008, 1, 32'hFFFF_FFFE, 0, "R3 status write");
    xfer('h000, 0, '0, 0, "R3 ctrl unchanged");

    xfer('h010, 0, '0, 0, "R4 bad offset");
    xfer('h001, 0, '0, 0, "R4 unaligned");
    xfer('h0FC, 1, 32'h0, 0, "R4 bad write");
    xfer('h000, 0, '0, 0, "R4 ctrl unchanged");

    for (int c = 0; c < 4; c++) xfer('h100 + 4*c + 8, 0, '0, c, "R5 self interface");
    for (int i = 0; i < 4; i++) xfer('h200 + 'h100*i + 'hFC, 0, '0, 0, "R5 direct interface");
    xfer('h2A0, 1, 32'hCAFE_0001, 1, "R5 interface write");

    for (int c = 0; c < 4; c++) xfer('h604, 0, '0, c, "R6 self timer");
    xfer('h61F, 0, '0, 0, "R6 timer top");
    xfer('h620, 0, '0, 1, "R6 self watchdog");
    xfer('h63F, 0, '0, 2, "R6 watchdog top");
    xfer('h640, 0, '0, 0, "R6 window gap");
    for (int k = 1; k < 6; k++) begin
      xfer('h600 + 'h100*k + 'h08, 0, '0, 0, "R6 direct timer");
      xfer('h600 + 'h100*k + 'h2C, 1, 32'h5A5A_0000 + 32'(k), 0, "R6 direct watchdog");
    end

    xfer('h1000, 0, '0, 0, "R7 distributor base");
    xfer('h1ABC, 0, '0, 2, "R7 distributor mid");
    xfer('h1FFC, 1, 32'h1234_5678, 1, "R7 distributor write");

    xfer('hB00, 0, '0, 0, "R8 gap low");
    xfer('hFFC, 0, '0, 0, "R8 gap high");
    xfer('h100, 1, 32'h1, 3, "R8 self alias id out of range");

    // back-pressure: hold responses for a few cycles
    step(1, 'h004, 0, '0, 0, 1, "R9 first", ok);
    step(1, 'h1004, 0, '0, 0, 0, "R9 stalled", ok);
    step(1, 'h1004, 0, '0, 0, 0, "R9 stalled", ok);
    while (!ok) step(1, 'h1004, 0, '0, 0, 1, "R9 released", ok);
    step(0, 0, 0, '0, 0, 0, "R9 hold", ok);
    step(0, 0, 0, '0, 0, 0, "R9 hold", ok);
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule